// File: doc/BRIEF.md
# Rewritable Boot ROM with Mirrored Hub Window

This block holds a 16 KB boot image that running software can overwrite one byte at a time through a packed 32-bit command word. A rewritten byte does not reach the executing image at once. After each reset, a copy engine moves the whole ROM into the top 16 KB of hub RAM at one byte per clock. Only then does it raise `boot_done_o`. Firmware therefore sees new ROM contents only after the next reset.

The block also contains the hub address decoder that sits in front of a 512 KB physical byte RAM. The RAM itself lies outside the block, on the `ram_*` port. The lower half of the 1 MB address space maps straight onto the RAM. The top 16 KB window at 0xFC000–0xFFFFF mirrors the physical top 16 KB, the same bytes seen at 0x7C000–0x7FFFF. The image runs from that upper window. Every address in between is unmapped.

A size flag is set only by power-on reset and can be cleared by firmware. It tells a loader whether the hub may be treated as 1 MB, so that code can be loaded up to 0xFFFFF.

Top module: `bootrom_hub`

## Requirements
- R1: A command with `cmd_valid_i` high and 0x30 in bits 31:24 writes the data byte in bits 23:16 to the ROM byte addressed by bits 13:0. After the next reset, that byte appears at hub address 0xFC000 plus the ROM address.
- R2: Bytes written by a command word that is incremented by one between writes land at consecutive ROM addresses.
- R3: Command bits 15:14 are ignored. Any command whose top byte is not 0x30 leaves the ROM unchanged.
- R4: A ROM write leaves the hub copy of the image unchanged until the next reset.
- R5: After `rst_ni` deasserts, ROM byte i is written to physical address 0x7C000+i, one byte per clock. `boot_done_o` rises on the 16384th rising clock edge and stays high until the next reset.
- R6: While `boot_done_o` is low, the hub port is held off: writes are dropped and reads return 0.
- R7: Hub addresses 0x7C000+k and 0xFC000+k (k < 0x4000) reach the same byte for both reads and writes.
- R8: Hub addresses 0x80000–0xFBFFF read as 0, and writes to them change no byte of RAM.
- R9: A ROM write command that arrives during the copy is held and applied once the copy completes. The copy always transfers the pre-write contents. One command can be held; a later one replaces it.
- R10: `size_1mb_o` is 1 after `por_ni` and is cleared by `size_clr_i`. `rst_ni` alone does not set it again.
- R11: Hub addresses 0x00000–0x7FFFF map directly to the physical byte. Read data is valid on `hub_rdata_o` in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset; restarts the boot copy |
| por_ni | input | 1 | Active-low power-on reset for the size flag |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 32 | Command word: opcode, data byte, ROM address |
| size_clr_i | input | 1 | Clears the 1 MB size flag |
| hub_en_i | input | 1 | Hub access request |
| hub_we_i | input | 1 | Hub write (1) or read (0) |
| hub_addr_i | input | 20 | Hub byte address |
| hub_wdata_i | input | 8 | Hub write data |
| hub_rdata_o | output | 8 | Hub read data, one cycle after request |
| size_1mb_o | output | 1 | Hub reports 1 MB size |
| boot_done_o | output | 1 | Boot copy complete |
| ram_en_o | output | 1 | Physical RAM enable |
| ram_we_o | output | 1 | Physical RAM write |
| ram_addr_o | output | 19 | Physical RAM byte address |
| ram_wdata_o | output | 8 | Physical RAM write data |
| ram_rdata_i | input | 8 | Physical RAM read data, one cycle latency |

## Verification
The bench builds the block with its default parameters: a 14-bit ROM index and a 19-bit physical hub. The full 16384-cycle copy and the true window boundaries at 0x7C000, 0x80000 and 0xFC000 are therefore exercised exactly as in the chip. The bench reaches the last ROM byte 0x3FFF through the mirror at 0xFFFFF. It also sees a write held at that address while the copy is still short of it, and runs four complete boots.

// File: rtl/bootrom_hub_pkg.sv
package bootrom_hub_pkg;
  localparam logic [7:0] ROM_WR_OP = 8'h30;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
  } rom_wr_t;
endpackage

// File: rtl/bootrom_store.sv
module bootrom_store #(
  parameter int unsigned AW     = 14,
  parameter int unsigned LANE_B = 3
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned LANES = 1 << LANE_B;
  localparam int unsigned WORDS = 1 << (AW - LANE_B);

  logic [LANES-1:0][7:0] lane_rd;

  // byte lanes in separate arrays keep each array shallow
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i[LANE_B-1:0] == LANE_B'(l))
        mem[waddr_i[AW-1:LANE_B]] <= wdata_i;
    end
    assign lane_rd[l] = mem[raddr_i[AW-1:LANE_B]];
  end

  assign rdata_o = lane_rd[raddr_i[LANE_B-1:0]];
endmodule

// File: rtl/boot_copier.sv
module boot_copier #(
  parameter int unsigned AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          busy_o,
  output logic [AW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      busy_o <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_o) begin
      if (idx_o == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && idx_o != LAST |=> busy_o && idx_o == $past(idx_o) + 1'b1);
  p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !busy_o);
endmodule

// File: rtl/hub_decode.sv
module hub_decode #(
  parameter int unsigned HUB_AW = 19,
  parameter int unsigned ROM_AW = 14
) (
  input  logic [HUB_AW:0]   addr_i,
  output logic              map_ok_o,
  output logic [HUB_AW-1:0] phys_o
);
  localparam int unsigned TOP_W = HUB_AW - ROM_AW;

  logic low, mirror;
  assign low      = !addr_i[HUB_AW];
  assign mirror   = &addr_i[HUB_AW:ROM_AW];
  assign map_ok_o = low || mirror;
  assign phys_o   = low ? addr_i[HUB_AW-1:0] : {{TOP_W{1'b1}}, addr_i[ROM_AW-1:0]};
endmodule

// File: rtl/bootrom_hub.sv
module bootrom_hub
  import bootrom_hub_pkg::*;
#(
  parameter int unsigned HUB_AW = 19,
  parameter int unsigned ROM_AW = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_i,
  input  logic              size_clr_i,
  input  logic              hub_en_i,
  input  logic              hub_we_i,
  input  logic [HUB_AW:0]   hub_addr_i,
  input  logic [7:0]        hub_wdata_i,
  output logic [7:0]        hub_rdata_o,
  output logic              size_1mb_o,
  output logic              boot_done_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [HUB_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i
);
  localparam int unsigned TOP_W = HUB_AW - ROM_AW;

  logic              copy_busy, map_ok, rd_ok_q, cmd_hit, rom_we;
  logic [ROM_AW-1:0] copy_idx;
  logic [HUB_AW-1:0] phys;
  logic [7:0]        rom_rd;
  rom_wr_t           cmd_w, pend_q, rom_w;
  logic              pend_v;
  logic              unused_cmd_bits;

  assign cmd_w           = '{addr: {{(16-ROM_AW){1'b0}}, cmd_i[ROM_AW-1:0]}, data: cmd_i[23:16]};
  assign unused_cmd_bits = ^cmd_i[15:ROM_AW];
  assign cmd_hit         = cmd_valid_i && cmd_i[31:24] == ROM_WR_OP;

  // held write drains first; a fresh command then takes its slot
  assign rom_we = !copy_busy && (pend_v || cmd_hit);
  assign rom_w  = pend_v ? pend_q : cmd_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v <= 1'b0;
      pend_q <= '0;
    end else if (cmd_hit && (copy_busy || pend_v)) begin
      pend_v <= 1'b1;
      pend_q <= cmd_w;
    end else if (!copy_busy) begin
      pend_v <= 1'b0;
    end
  end

  bootrom_store #(.AW(ROM_AW)) i_store (
    .clk_i   (clk_i),
    .we_i    (rom_we),
    .waddr_i (rom_w.addr[ROM_AW-1:0]),
    .wdata_i (rom_w.data),
    .raddr_i (copy_idx),
    .rdata_o (rom_rd)
  );

  boot_copier #(.AW(ROM_AW)) i_copier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_o (copy_busy),
    .idx_o  (copy_idx),
    .done_o (boot_done_o)
  );

  hub_decode #(.HUB_AW(HUB_AW), .ROM_AW(ROM_AW)) i_decode (
    .addr_i   (hub_addr_i),
    .map_ok_o (map_ok),
    .phys_o   (phys)
  );

  always_comb begin
    if (copy_busy) begin
      ram_en_o    = 1'b1;
      ram_we_o    = 1'b1;
      ram_addr_o  = {{TOP_W{1'b1}}, copy_idx};
      ram_wdata_o = rom_rd;
    end else begin
      ram_en_o    = boot_done_o && hub_en_i && map_ok;
      ram_we_o    = hub_we_i;
      ram_addr_o  = phys;
      ram_wdata_o = hub_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_ok_q <= 1'b0;
    else         rd_ok_q <= boot_done_o && hub_en_i && !hub_we_i && map_ok;
  end
  assign hub_rdata_o = rd_ok_q ? ram_rdata_i : 8'h00;

  logic size_q;
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)         size_q <= 1'b1;
    else if (size_clr_i) size_q <= 1'b0;
  end
  assign size_1mb_o = size_q;

  p_hold_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_done_o && ram_we_o |-> &ram_addr_o[HUB_AW-1:ROM_AW]);
  p_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_busy && cmd_hit |=> pend_v);
  p_rom_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_we |-> boot_done_o);
  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o && hub_en_i && !map_ok |-> !ram_en_o);
  p_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o && hub_en_i && !hub_we_i && !map_ok |=> hub_rdata_o == 8'h00);
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    !size_1mb_o |=> !size_1mb_o);
endmodule

// File: tb/test_bootrom_hub.sv
module test_bootrom_hub;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_BYTES  = 16384;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        cmd_valid = 1'b0, size_clr = 1'b0;
  logic [31:0] cmd = '0;
  logic        hub_en = 1'b0, hub_we = 1'b0;
  logic [19:0] hub_addr = '0;
  logic [7:0]  hub_wdata = '0, hub_rdata;
  logic        size_1mb, boot_done;
  logic        ram_en, ram_we;
  logic [18:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata = '0;

  int n_cmp = 0, n_bad = 0;
  int edges = 0, rel_edge = 0;
  logic [7:0] hub_mem [int];
  logic [7:0] old_00, old_21, rd;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  // physical RAM model, one-cycle read
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) hub_mem[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= hub_mem.exists(int'(ram_addr)) ? hub_mem[int'(ram_addr)] : 8'h00;
    end
  end

  bootrom_hub i_bootrom_hub (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .size_clr_i(size_clr),
    .hub_en_i(hub_en), .hub_we_i(hub_we), .hub_addr_i(hub_addr),
    .hub_wdata_i(hub_wdata), .hub_rdata_o(hub_rdata),
    .size_1mb_o(size_1mb), .boot_done_o(boot_done),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'hA0 ^ 8'(i * 7);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hub_wr(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    hub_en = 1'b1; hub_we = 1'b1; hub_addr = a; hub_wdata = d;
    @(negedge clk);
    hub_en = 1'b0; hub_we = 1'b0;
  endtask

  task automatic hub_rd(logic [19:0] a, output logic [7:0] d);
    @(negedge clk);
    hub_en = 1'b1; hub_we = 1'b0; hub_addr = a;
    @(negedge clk);
    d = hub_rdata;
    hub_en = 1'b0;
  endtask

  task automatic send_cmd(logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic start_reset(bit with_por);
    @(negedge clk);
    rst_ni = 1'b0;
    if (with_por) por_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; por_ni = 1'b1;
    rel_edge = edges;
  endtask

  task automatic finish_boot(string tag);
    while (!boot_done) @(negedge clk);
    chk(tag, edges - rel_edge, ROM_BYTES);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_ni = 1'b0; por_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 done low in reset", boot_done, 1'b0);
    chk("R10 size flag after por", size_1mb, 1'b1);
    chk("R6 rdata in reset", hub_rdata, 8'h00);
    rst_ni = 1'b1; por_ni = 1'b1;
    rel_edge = edges;
    hub_rd(20'h00010, rd);
    chk("R6 read during copy", rd, 8'h00);
    finish_boot("R5 first boot cycles");
  endtask

  task automatic t_hub_map;
    hub_wr(20'h00010, 8'h3C);
    hub_rd(20'h00010, rd);
    chk("R11 direct low", rd, 8'h3C);
    hub_wr(20'h7FFF0, 8'h5E);
    hub_rd(20'h7FFF0, rd);
    chk("R11 direct top", rd, 8'h5E);
    hub_wr(20'h7C020, 8'h77);
    hub_rd(20'hFC020, rd);
    chk("R7 low window to high", rd, 8'h77);
    hub_wr(20'hFFFF0, 8'h6B);
    hub_rd(20'h7FFF0, rd);
    chk("R7 high window to low", rd, 8'h6B);
    hub_wr(20'h10000, 8'h12);
    hub_wr(20'h90000, 8'hEE);
    hub_rd(20'h90000, rd);
    chk("R8 unmapped read", rd, 8'h00);
    hub_rd(20'h10000, rd);
    chk("R8 write dropped", rd, 8'h12);
    hub_wr(20'hFBFFF, 8'hEF);
    hub_rd(20'hFBFFF, rd);
    chk("R8 last unmapped", rd, 8'h00);
    hub_rd(20'h7BFFF, rd);
    chk("R8 no alias below window", rd, 8'h00);
  endtask

  task automatic t_rom_write;
    logic [31:0] w;
    hub_rd(20'hFC000, old_00);
    hub_rd(20'hFC021, old_21);
    w = 32'h3000_0000;
    for (int i = 0; i < 16; i++) begin
      w[23:16] = pat(i);
      send_cmd(w);
      w = w + 1;
    end
    send_cmd(32'h305A_C020);  // R3 bits 15:14 set
    send_cmd(32'h31BB_0021);  // R3 wrong opcode
    send_cmd(32'h00BB_0021);  // R3 wrong opcode
    send_cmd(32'h30C3_3FFF);
    hub_rd(20'hFC000, rd);
    chk("R4 image unchanged before reset", rd, old_00);
  endtask

  task automatic t_reboot;
    start_reset(1'b0);
    repeat (50) @(negedge clk);
    send_cmd(32'h3099_3FFF);  // R9 lands while copy is below 0x3FFF
    hub_wr(20'h00010, 8'h55);
    hub_rd(20'h00010, rd);
    chk("R6 read held off", rd, 8'h00);
    finish_boot("R5 reboot cycles");
    for (int i = 0; i < 16; i++) begin
      hub_rd(20'hFC000 + 20'(i), rd);
      chk($sformatf("R2 R1 rom byte %0d", i), rd, pat(i));
    end
    hub_rd(20'hFC020, rd);
    chk("R3 bits 15:14 ignored", rd, 8'h5A);
    hub_rd(20'hFC021, rd);
    chk("R3 foreign opcode ignored", rd, old_21);
    hub_rd(20'hFFFFF, rd);
    chk("R9 copy saw pre-write byte", rd, 8'hC3);
    hub_rd(20'h7FFFF, rd);
    chk("R7 copy visible in low window", rd, 8'hC3);
    hub_rd(20'h00010, rd);
    chk("R6 write during copy dropped", rd, 8'h3C);
    chk("R10 flag kept over reset", size_1mb, 1'b1);
  endtask

  task automatic t_flag_and_pending;
    @(negedge clk);
    size_clr = 1'b1;
    @(negedge clk);
    size_clr = 1'b0;
    chk("R10 flag cleared", size_1mb, 1'b0);
    start_reset(1'b0);
    finish_boot("R5 third boot cycles");
    chk("R10 rst does not set flag", size_1mb, 1'b0);
    hub_rd(20'hFFFFF, rd);
    chk("R9 held write applied", rd, 8'h99);
    hub_rd(20'hFC000, rd);
    chk("R1 byte 0 at window base", rd, pat(0));
    start_reset(1'b1);
    chk("R10 por sets flag", size_1mb, 1'b1);
    finish_boot("R5 fourth boot cycles");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_hub_map();
    t_rom_write();
    t_reboot();
    t_flag_and_pending();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule